// File: doc/BRIEF.md
# Single-Bus Processor Datapath

This block is the register-transfer core of a small processor. The program counter, memory address register, memory data register, instruction register, a general register file, the ALU operand latch Y and the ALU result latch Z all share one internal bus. In any clock cycle one source drives that bus, and any set of destinations may capture it on the same rising edge. An external sequencer steps the block through fetch and execute. It does this by raising one-hot source enables, load strobes and ALU controls once per step.

The ALU adds or subtracts. Its first operand is either Y or the constant four, and its second operand is the bus. The result can only be captured in Z, and it reaches the bus only when Z is selected as the source. This means that an operation such as incrementing the PC or adding two registers takes several steps. Memory is reached through the MAR, which drives the address lines. Reads complete when memory raises its function-complete input, and the MDR carries write data. The sequencer sees the opcode and offset fields of the instruction register, and a negative flag for conditional branches.

Top module: `sbus_datapath`

## Requirements
- R1: While rstN is low, and after it rises until a load occurs, the PC, MAR, MDR, IR, Y, Z, every general register and the negative flag hold zero, so memAddr, memWData, irOpcode, irOffset and nFlag read zero.
- R2: With exactly one source enable high, the bus carries that source's value, and every destination whose load strobe is high captures it on the same rising edge. The sequencer raises at most one source enable per cycle, and an assertion flags any cycle with more than one.
- R3: The ALU computes A+bus, or A-bus when aluSub is 1. A is the constant 4 when useConst4 is 1, and Y otherwise. Z captures the result only on an edge where zIn is 1, and holds its value otherwise.
- R4: nFlag takes bit DATA_W-1 of the ALU result on every edge where zIn is 1, and keeps its value on all other edges.
- R5: memAddr always shows the MAR. memRd equals rdReq and memWr equals wrReq within the same cycle, and memWData always shows the MDR.
- R6: A read started by rdReq completes on the first edge where mfc is 1, which may be in the same cycle as rdReq. On that edge the MDR captures memRData. An mfc with no outstanding read leaves the MDR unchanged.
- R7: When mdrIn is high, the MDR loads from the bus. If a read completes on the same edge, the memory data wins.
- R8: The addrOut source drives the low ADDR_W (25) bits of the IR onto the bus, zero-extended.
- R9: irOpcode shows the IR's upper DATA_W-ADDR_W (7) bits, and irOffset shows its low OFF_W (16) bits. The offOut source drives those 16 offset bits onto the bus, sign-extended from bit 15.
- R10: The PC is ADDR_W bits wide, the same width as memAddr. pcIn loads the low ADDR_W bits of the bus, and pcOut drives the PC zero-extended to DATA_W bits.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rstN | input | 1 | Active-low synchronous reset |
| pcOut | input | 1 | Bus source: PC (zero-extended) |
| zOut | input | 1 | Bus source: Z |
| mdrOut | input | 1 | Bus source: MDR |
| offOut | input | 1 | Bus source: IR offset field, sign-extended |
| addrOut | input | 1 | Bus source: IR address field, zero-extended |
| regOut | input | NREG | Bus sources: general registers, one bit each |
| pcIn | input | 1 | Load PC from bus |
| marIn | input | 1 | Load MAR from bus |
| mdrIn | input | 1 | Load MDR from bus |
| irIn | input | 1 | Load IR from bus |
| yIn | input | 1 | Load Y from bus |
| zIn | input | 1 | Load Z and nFlag from ALU |
| regIn | input | NREG | Load general registers from bus |
| useConst4 | input | 1 | ALU A operand: 1 = constant 4, 0 = Y |
| aluSub | input | 1 | ALU operation: 1 = subtract, 0 = add |
| rdReq | input | 1 | Start a memory read |
| wrReq | input | 1 | Request a memory write |
| mfc | input | 1 | Memory function complete |
| memRData | input | DATA_W | Memory read data |
| memAddr | output | ADDR_W | Memory address (MAR) |
| memRd | output | 1 | Memory read strobe |
| memWr | output | 1 | Memory write strobe |
| memWData | output | DATA_W | Memory write data (MDR) |
| irOpcode | output | DATA_W-ADDR_W | IR opcode field |
| irOffset | output | OFF_W | IR offset field |
| nFlag | output | 1 | Sign of last captured ALU result |

## Verification
The ALU path is driven by a table of operand sets: Y plus bus, the constant four plus bus, subtraction that gives zero, subtraction that goes negative, and an addition that carries into the sign bit. These show whether the A-operand select, the operation select and the flag update are wired independently. Directed sequences move values between the general registers, MDR, PC and MAR. They also load an IR word whose offset sign bit and address-field top bit are both set, which separates sign extension from zero extension. Finally, they issue a delayed read, a stray completion and a collision between a bus load and a memory load on the MDR.

// File: rtl/sbus_pkg.sv
package sbus_pkg;
  localparam int DATA_W = 32;
  localparam int ADDR_W = 25;
  localparam int OFF_W  = 16;
  localparam int NREG   = 4;
  localparam int OPC_W  = DATA_W - ADDR_W;

  // Bus source indices; a lower index wins if the sequencer misbehaves.
  localparam int SRC_PC   = 0;
  localparam int SRC_Z    = 1;
  localparam int SRC_MDR  = 2;
  localparam int SRC_OFF  = 3;
  localparam int SRC_ADDR = 4;
  localparam int SRC_REG0 = 5;
  localparam int NSRC     = SRC_REG0 + NREG;

  typedef struct packed {
    logic [NSRC-1:0] srcSel;
    logic            pcLoad;
    logic            marLoad;
    logic            mdrLoadBus;
    logic            mdrLoadMem;
    logic            irLoad;
    logic            yLoad;
    logic            zLoad;
    logic            useConst4;
    logic            aluSub;
    logic [NREG-1:0] regLoad;
  } strobes_t;
endpackage

// File: rtl/sbus_alu.sv
module sbus_alu
  import sbus_pkg::*;
(
  input  logic [DATA_W-1:0] opA,
  input  logic [DATA_W-1:0] opB,
  input  logic              doSub,
  output logic [DATA_W-1:0] result
);
  always_comb begin
    if (doSub) result = opA - opB;
    else       result = opA + opB;
  end
endmodule

// File: rtl/sbus_ctrl.sv
module sbus_ctrl
  import sbus_pkg::*;
(
  input  logic            clk,
  input  logic            rstN,
  input  logic [NSRC-1:0] srcReq,
  input  logic            pcIn,
  input  logic            marIn,
  input  logic            mdrIn,
  input  logic            irIn,
  input  logic            yIn,
  input  logic            zIn,
  input  logic [NREG-1:0] regIn,
  input  logic            useConst4,
  input  logic            aluSub,
  input  logic            rdReq,
  input  logic            mfc,
  output strobes_t        strb
);
  logic readPending;
  logic readDone;

  assign readDone = mfc & (rdReq | readPending);

  // Outstanding read: raised by a request, dropped on completion.
  always_ff @(posedge clk) begin
    if (!rstN)            readPending <= 1'b0;
    else if (mfc)         readPending <= 1'b0;
    else if (rdReq)       readPending <= 1'b1;
  end

  always_comb begin
    strb.srcSel     = srcReq & (~srcReq + NSRC'(1));  // keep lowest set bit
    strb.pcLoad     = pcIn;
    strb.marLoad    = marIn;
    strb.mdrLoadMem = readDone;
    strb.mdrLoadBus = mdrIn & ~readDone;
    strb.irLoad     = irIn;
    strb.yLoad      = yIn;
    strb.zLoad      = zIn;
    strb.useConst4  = useConst4;
    strb.aluSub     = aluSub;
    strb.regLoad    = regIn;
  end

  // R2: sequencer must never enable two bus sources together
  a_r2_single_source: assert property (@(posedge clk) disable iff (!rstN)
    $onehot0(srcReq));

  // R6: completion always retires the outstanding read
  a_r6_pending_clears: assert property (@(posedge clk) disable iff (!rstN)
    mfc |=> !readPending);

  // R6: stray completion never loads MDR from memory
  a_r6_stray_mfc: assert property (@(posedge clk) disable iff (!rstN)
    (mfc && !rdReq && !readPending) |-> !strb.mdrLoadMem);
endmodule

// File: rtl/sbus_regs.sv
module sbus_regs
  import sbus_pkg::*;
(
  input  logic              clk,
  input  logic              rstN,
  input  strobes_t          strb,
  input  logic [DATA_W-1:0] memRData,
  output logic [ADDR_W-1:0] marQ,
  output logic [DATA_W-1:0] mdrQ,
  output logic [OPC_W-1:0]  irOpcode,
  output logic [OFF_W-1:0]  irOffset,
  output logic              nFlag
);
  logic [ADDR_W-1:0] pcReg;
  logic [DATA_W-1:0] irReg, yReg, zReg;
  logic [DATA_W-1:0] regFile [NREG];
  logic [DATA_W-1:0] srcVal  [NSRC];
  logic [DATA_W-1:0] busVal, aluA, aluRes;

  assign srcVal[SRC_PC]   = {{OPC_W{1'b0}}, pcReg};
  assign srcVal[SRC_Z]    = zReg;
  assign srcVal[SRC_MDR]  = mdrQ;
  assign srcVal[SRC_OFF]  = {{(DATA_W-OFF_W){irReg[OFF_W-1]}}, irReg[OFF_W-1:0]};
  assign srcVal[SRC_ADDR] = {{OPC_W{1'b0}}, irReg[ADDR_W-1:0]};

  for (genvar g = 0; g < NREG; g++) begin : gRegSrc
    assign srcVal[SRC_REG0+g] = regFile[g];
  end

  // One-hot AND-OR bus: the stand-in for tri-state drivers.
  always_comb begin
    busVal = '0;
    for (int i = 0; i < NSRC; i++)
      if (strb.srcSel[i]) busVal = busVal | srcVal[i];
  end

  assign aluA = strb.useConst4 ? DATA_W'(4) : yReg;

  sbus_alu uAlu (
    .opA   (aluA),
    .opB   (busVal),
    .doSub (strb.aluSub),
    .result(aluRes)
  );

  always_ff @(posedge clk) begin
    if (!rstN) begin
      pcReg <= '0;
      marQ  <= '0;
      mdrQ  <= '0;
      irReg <= '0;
      yReg  <= '0;
      zReg  <= '0;
      nFlag <= 1'b0;
      for (int r = 0; r < NREG; r++) regFile[r] <= '0;
    end else begin
      if (strb.pcLoad)          pcReg <= busVal[ADDR_W-1:0];
      if (strb.marLoad)         marQ  <= busVal[ADDR_W-1:0];
      if (strb.mdrLoadMem)      mdrQ  <= memRData;
      else if (strb.mdrLoadBus) mdrQ  <= busVal;
      if (strb.irLoad)          irReg <= busVal;
      if (strb.yLoad)           yReg  <= busVal;
      if (strb.zLoad) begin
        zReg  <= aluRes;
        nFlag <= aluRes[DATA_W-1];
      end
      for (int r = 0; r < NREG; r++)
        if (strb.regLoad[r]) regFile[r] <= busVal;
    end
  end

  assign irOpcode = irReg[DATA_W-1 -: OPC_W];
  assign irOffset = irReg[OFF_W-1:0];

  // R2: resolved selection reaching the bus is never multi-hot
  a_r2_resolved_onehot: assert property (@(posedge clk) disable iff (!rstN)
    $onehot0(strb.srcSel));

  // R3: Z only moves on a capture edge
  a_r3_z_hold: assert property (@(posedge clk) disable iff (!rstN)
    !strb.zLoad |=> $stable(zReg));

  // R4: flag only moves on a capture edge
  a_r4_n_hold: assert property (@(posedge clk) disable iff (!rstN)
    !strb.zLoad |=> $stable(nFlag));

  // R7: memory completion lands its data in MDR
  a_r7_mdr_mem: assert property (@(posedge clk) disable iff (!rstN)
    strb.mdrLoadMem |=> (mdrQ == $past(memRData)));
endmodule

// File: rtl/sbus_datapath.sv
module sbus_datapath
  import sbus_pkg::*;
(
  input  logic              clk,
  input  logic              rstN,
  input  logic              pcOut,
  input  logic              zOut,
  input  logic              mdrOut,
  input  logic              offOut,
  input  logic              addrOut,
  input  logic [NREG-1:0]   regOut,
  input  logic              pcIn,
  input  logic              marIn,
  input  logic              mdrIn,
  input  logic              irIn,
  input  logic              yIn,
  input  logic              zIn,
  input  logic [NREG-1:0]   regIn,
  input  logic              useConst4,
  input  logic              aluSub,
  input  logic              rdReq,
  input  logic              wrReq,
  input  logic              mfc,
  input  logic [DATA_W-1:0] memRData,
  output logic [ADDR_W-1:0] memAddr,
  output logic              memRd,
  output logic              memWr,
  output logic [DATA_W-1:0] memWData,
  output logic [OPC_W-1:0]  irOpcode,
  output logic [OFF_W-1:0]  irOffset,
  output logic              nFlag
);
  strobes_t        strb;
  logic [NSRC-1:0] srcReq;

  assign srcReq = {regOut, addrOut, offOut, mdrOut, zOut, pcOut};
  assign memRd  = rdReq;
  assign memWr  = wrReq;

  sbus_ctrl uCtrl (
    .clk      (clk),
    .rstN     (rstN),
    .srcReq   (srcReq),
    .pcIn     (pcIn),
    .marIn    (marIn),
    .mdrIn    (mdrIn),
    .irIn     (irIn),
    .yIn      (yIn),
    .zIn      (zIn),
    .regIn    (regIn),
    .useConst4(useConst4),
    .aluSub   (aluSub),
    .rdReq    (rdReq),
    .mfc      (mfc),
    .strb     (strb)
  );

  sbus_regs uRegs (
    .clk     (clk),
    .rstN    (rstN),
    .strb    (strb),
    .memRData(memRData),
    .marQ    (memAddr),
    .mdrQ    (memWData),
    .irOpcode(irOpcode),
    .irOffset(irOffset),
    .nFlag   (nFlag)
  );
endmodule

// File: tb/sbus_datapath_test.sv
module sbus_datapath_test;
  import sbus_pkg::*;

  logic clk = 1'b0;
  logic rstN;
  logic pcOut, zOut, mdrOut, offOut, addrOut;
  logic [NREG-1:0] regOut, regIn;
  logic pcIn, marIn, mdrIn, irIn, yIn, zIn, useConst4, aluSub;
  logic rdReq, wrReq, mfc;
  logic [DATA_W-1:0] memRData;
  logic [ADDR_W-1:0] memAddr;
  logic memRd, memWr, nFlag;
  logic [DATA_W-1:0] memWData;
  logic [OPC_W-1:0]  irOpcode;
  logic [OFF_W-1:0]  irOffset;

  int nChecks = 0;
  int nErrors = 0;

  always #2 clk = ~clk;  // 250 MHz

  sbus_datapath uut (.*);

  typedef struct packed {
    logic [31:0] yVal;
    logic        c4;
    logic        sub;
    logic [31:0] bVal;
    logic [31:0] zExp;
    logic        nExp;
  } vec_t;

  localparam vec_t VECS [5] = '{
    '{32'd10,         1'b0, 1'b0, 32'd5,     32'd15,        1'b0},
    '{32'd0,          1'b1, 1'b0, 32'h100,   32'h104,       1'b0},
    '{32'd0,          1'b1, 1'b1, 32'd4,     32'd0,         1'b0},
    '{32'd3,          1'b0, 1'b1, 32'd5,     32'hFFFF_FFFE, 1'b1},
    '{32'h7FFF_FFFF,  1'b0, 1'b0, 32'd1,     32'h8000_0000, 1'b1}
  };

  task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
    nChecks++;
    if (act !== exp) begin
      nErrors++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic idle();
    {pcOut, zOut, mdrOut, offOut, addrOut} = '0;
    regOut = '0; regIn = '0;
    {pcIn, marIn, mdrIn, irIn, yIn, zIn, useConst4, aluSub} = '0;
    {rdReq, wrReq, mfc} = '0;
  endtask

  task automatic tick();
    @(posedge clk);
    @(negedge clk);
    idle();
  endtask

  task automatic memLoad(input logic [31:0] v);
    rdReq = 1'b1; mfc = 1'b1; memRData = v;
    tick();
  endtask

  initial begin
    #400000;
    nErrors++;
    $display("FAIL watchdog actual=%h expected=%h", 32'd0, 32'd1);
    $display("CHECKS %0d ERRORS %0d", nChecks, nErrors);
    $finish;
  end

  initial begin
    idle();
    memRData = '0;
    rstN = 1'b0;
    repeat (3) @(negedge clk);
    // R1: reset state
    check("R1 memAddr", 32'(memAddr), 32'd0);
    check("R1 memWData", memWData, 32'd0);
    check("R1 irOpcode", 32'(irOpcode), 32'd0);
    check("R1 irOffset", 32'(irOffset), 32'd0);
    check("R1 nFlag", 32'(nFlag), 32'd0);
    rstN = 1'b1;
    @(negedge clk);

    // R3 / R4: ALU table
    foreach (VECS[i]) begin
      memLoad(VECS[i].yVal);
      mdrOut = 1'b1; yIn = 1'b1; tick();
      memLoad(VECS[i].bVal);
      mdrOut = 1'b1; zIn = 1'b1; useConst4 = VECS[i].c4; aluSub = VECS[i].sub; tick();
      check($sformatf("R4 nFlag vec%0d", i), 32'(nFlag), 32'(VECS[i].nExp));
      zOut = 1'b1; mdrIn = 1'b1; tick();
      check($sformatf("R3 zResult vec%0d", i), memWData, VECS[i].zExp);
    end

    // R3 / R4: Z and flag hold without zIn
    memLoad(32'h0000_0099);
    mdrOut = 1'b1; yIn = 1'b1; tick();
    zOut = 1'b1; mdrIn = 1'b1; tick();
    check("R3 z hold", memWData, 32'h8000_0000);
    check("R4 n hold", 32'(nFlag), 32'd1);

    // R2: register round trip through the bus
    memLoad(32'h0000_1234);
    mdrOut = 1'b1; regIn[2] = 1'b1; tick();
    memLoad(32'd0);
    regOut[2] = 1'b1; mdrIn = 1'b1; tick();
    check("R2 reg2 to mdr", memWData, 32'h0000_1234);

    // R7: memory completion beats bus load
    rdReq = 1'b1; mfc = 1'b1; memRData = 32'h0000_0077;
    regOut[2] = 1'b1; mdrIn = 1'b1; tick();
    check("R7 mem wins", memWData, 32'h0000_0077);

    // R6: delayed completion, then stray completion
    rdReq = 1'b1; memRData = 32'hDEAD_0000; tick();
    check("R6 no capture before mfc", memWData, 32'h0000_0077);
    tick();
    mfc = 1'b1; memRData = 32'h0000_AAAA; tick();
    check("R6 delayed capture", memWData, 32'h0000_AAAA);
    mfc = 1'b1; memRData = 32'h0000_5555; tick();
    check("R6 stray mfc ignored", memWData, 32'h0000_AAAA);

    // R8 / R9: IR fields
    memLoad(32'hFF00_8ABC);
    mdrOut = 1'b1; irIn = 1'b1; tick();
    check("R9 irOpcode", 32'(irOpcode), 32'h7F);
    check("R9 irOffset", 32'(irOffset), 32'h8ABC);
    offOut = 1'b1; mdrIn = 1'b1; tick();
    check("R9 offset sign ext", memWData, 32'hFFFF_8ABC);
    addrOut = 1'b1; mdrIn = 1'b1; marIn = 1'b1; tick();
    check("R8 addr zero ext", memWData, 32'h0100_8ABC);
    check("R5 memAddr from MAR", 32'(memAddr), 32'h0100_8ABC);

    // R10: PC width and increment
    memLoad(32'hFFFF_FFF0);
    mdrOut = 1'b1; pcIn = 1'b1; tick();
    pcOut = 1'b1; mdrIn = 1'b1; marIn = 1'b1; tick();
    check("R10 pc zero ext", memWData, 32'h01FF_FFF0);
    check("R10 pc to mar", 32'(memAddr), 32'h01FF_FFF0);
    pcOut = 1'b1; useConst4 = 1'b1; zIn = 1'b1; tick();
    zOut = 1'b1; pcIn = 1'b1; tick();
    pcOut = 1'b1; marIn = 1'b1; tick();
    check("R10 pc plus 4", 32'(memAddr), 32'h01FF_FFF4);

    // R5: strobes pass through
    rdReq = 1'b1; #1;
    check("R5 memRd", 32'(memRd), 32'd1);
    rdReq = 1'b0; wrReq = 1'b1; #1;
    check("R5 memWr", 32'(memWr), 32'd1);
    check("R5 memRd low", 32'(memRd), 32'd0);
    wrReq = 1'b0;
    tick();

    $display("CHECKS %0d ERRORS %0d", nChecks, nErrors);
    $finish;
  end
endmodule